// File: doc/BRIEF.md
# FIFO Threshold Service-Request Controller

This block sits beside the sample FIFOs of a serial audio port. It compares the fill level of the transmit FIFO and of the receive FIFO against a programmable limit for each direction. The limit is counted in single samples, so a limit of 8 stands for four stereo pairs. Transmit asks for service while its FIFO is running low. Receive asks for service while its FIFO is filling up. Each service request goes to a DMA request line, and also to the processor as an interrupt source.

Each direction has a service-enable bit that gates its request. Each direction also has an error event input. An error event is held in a sticky status bit until it is cleared by a write-one pulse. A top-level mask selects which of the four status sources reach the single interrupt line. The raw status, the masked status and the interrupt are all visible at the ports. The FIFOs and the register decode live outside this block.

Top module: `fifo_svc_req_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, raw status, masked status, both DMA requests and the interrupt are all zero.
- R2: Raw status bit 0 (transmit service) is 1 exactly when the transmit level was strictly below the transmit limit at the previous clock edge. A limit of 0 therefore never requests.
- R3: Raw status bit 4 (receive service) is 1 exactly when the receive level was strictly above the receive limit at the previous clock edge.
- R4: Each DMA request equals that direction's threshold result ANDed with its service-enable bit, registered once. It has the same latency as the raw bit.
- R5: An error event pulse sets the sticky raw bit one cycle later: bit 1 for transmit, bit 5 for receive. The bit stays set until it is cleared.
- R6: A one on a direction's clear input zeroes its sticky error bit at the next edge. If an event arrives in the same cycle as the clear, the event wins.
- R7: The masked status follows the raw status with no extra delay, with these gates:
  - bit 0 = raw0 & tx service enable & mask0
  - bit 1 = raw1 & mask1
  - bit 4 = raw4 & rx service enable & mask4
  - bit 5 = raw5 & mask5
  - Bits 2 and 3 of both status words are always 0, and mask bits 2 and 3 have no effect.
- R8: The interrupt is the OR of the masked status bits, registered once. It rises or falls one cycle after the masked status changes.
- R9: A level equal to its limit gives no service request in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Transmit FIFO fill, in samples |
| tx_limit | input | LVL_W | Transmit service limit, in samples |
| tx_svc_en | input | 1 | Transmit service-request enable |
| tx_err_evt | input | 1 | Transmit error event pulse |
| tx_err_clr | input | 1 | Write-one clear for the transmit error bit |
| rx_level | input | LVL_W | Receive FIFO fill, in samples |
| rx_limit | input | LVL_W | Receive service limit, in samples |
| rx_svc_en | input | 1 | Receive service-request enable |
| rx_err_evt | input | 1 | Receive error event pulse |
| rx_err_clr | input | 1 | Write-one clear for the receive error bit |
| irq_mask | input | 6 | Interrupt source mask (bits 0, 1, 4, 5 used) |
| raw_stat | output | 6 | Raw status |
| masked_stat | output | 6 | Raw status after the enable and mask gates |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Different results arrive after different delays:
- A change on a level, a limit or an error input reaches the raw status, the masked status and the DMA lines one edge later, and reaches the interrupt two edges later.
- A change on a mask or enable input reaches the masked status at once, and reaches the interrupt one edge later.

Table vectors hold their inputs for two edges and are sampled on the falling edge that follows, so every result has settled. The directed tests sample on the falling edge right after the first edge, and again after the second. This pins down the exact cycle of each sticky-bit change and each interrupt change.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned STAT_W     = 6;
  localparam int unsigned TX_SVC_BIT = 0;
  localparam int unsigned TX_ERR_BIT = 1;
  localparam int unsigned RX_SVC_BIT = 4;
  localparam int unsigned RX_ERR_BIT = 5;
  localparam logic [STAT_W-1:0] LIVE_BITS = 6'b11_0011;

  typedef enum logic {
    SENSE_BELOW = 1'b0,
    SENSE_ABOVE = 1'b1
  } sense_e;
endpackage

// File: rtl/fsr_level_cmp.sv
module fsr_level_cmp
  import fsr_pkg::*;
#(
  parameter int unsigned LVL_W = 6,
  parameter sense_e      SENSE = SENSE_BELOW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] limit,
  input  logic             svc_en,
  output logic             hit,
  output logic             req
);
  logic cmp;

  generate
    if (SENSE == SENSE_BELOW) begin : g_below
      assign cmp = (level < limit);
    end else begin : g_above
      assign cmp = (level > limit);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
      req <= 1'b0;
    end else begin
      hit <= cmp;
      req <= cmp & svc_en;
    end
  end
endmodule

// File: rtl/fsr_sticky_err.sv
module fsr_sticky_err #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flag[i] <= 1'b0;
      end else begin
        flag[i] <= (flag[i] & ~clr[i]) | evt[i];
      end
    end
  end
endmodule

// File: rtl/fsr_irq_merge.sv
module fsr_irq_merge #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] gate,
  output logic [W-1:0] masked,
  output logic         irq
);
  assign masked = raw & gate;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked;
  end
endmodule

// File: rtl/fifo_svc_req_ctrl.sv
module fifo_svc_req_ctrl
  import fsr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  tx_limit,
  input  logic              tx_svc_en,
  input  logic              tx_err_evt,
  input  logic              tx_err_clr,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rx_limit,
  input  logic              rx_svc_en,
  input  logic              rx_err_evt,
  input  logic              rx_err_clr,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] raw_stat,
  output logic [STAT_W-1:0] masked_stat,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  localparam int unsigned NDIR = 2;

  logic            tx_hit, rx_hit;
  logic [NDIR-1:0] err_flag;
  logic [STAT_W-1:0] gate;

  fsr_level_cmp #(.LVL_W(LVL_W), .SENSE(SENSE_BELOW)) u_tx_cmp (
    .clk(clk), .rst(rst), .level(tx_level), .limit(tx_limit),
    .svc_en(tx_svc_en), .hit(tx_hit), .req(tx_dma_req)
  );

  fsr_level_cmp #(.LVL_W(LVL_W), .SENSE(SENSE_ABOVE)) u_rx_cmp (
    .clk(clk), .rst(rst), .level(rx_level), .limit(rx_limit),
    .svc_en(rx_svc_en), .hit(rx_hit), .req(rx_dma_req)
  );

  fsr_sticky_err #(.N(NDIR)) u_err (
    .clk(clk), .rst(rst),
    .evt({rx_err_evt, tx_err_evt}),
    .clr({rx_err_clr, tx_err_clr}),
    .flag(err_flag)
  );

  always_comb begin
    raw_stat             = '0;
    raw_stat[TX_SVC_BIT] = tx_hit;
    raw_stat[TX_ERR_BIT] = err_flag[0];
    raw_stat[RX_SVC_BIT] = rx_hit;
    raw_stat[RX_ERR_BIT] = err_flag[1];
  end

  always_comb begin
    gate             = irq_mask & LIVE_BITS;
    gate[TX_SVC_BIT] = irq_mask[TX_SVC_BIT] & tx_svc_en;
    gate[RX_SVC_BIT] = irq_mask[RX_SVC_BIT] & rx_svc_en;
  end

  fsr_irq_merge #(.W(STAT_W)) u_merge (
    .clk(clk), .rst(rst), .raw(raw_stat), .gate(gate),
    .masked(masked_stat), .irq(irq)
  );
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk
  import fsr_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  tx_limit,
  input logic              tx_err_evt,
  input logic              tx_err_clr,
  input logic [LVL_W-1:0]  rx_level,
  input logic [LVL_W-1:0]  rx_limit,
  input logic              rx_err_evt,
  input logic              rx_err_clr,
  input logic [STAT_W-1:0] raw_stat,
  input logic [STAT_W-1:0] masked_stat,
  input logic              irq,
  input logic              tx_dma_req,
  input logic              rx_dma_req
);
  AST_TX_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> raw_stat[TX_SVC_BIT] == ($past(tx_level) < $past(tx_limit))); // R2
  AST_RX_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> raw_stat[RX_SVC_BIT] == ($past(rx_level) > $past(rx_limit))); // R3
  AST_TX_DMA_GATED: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> raw_stat[TX_SVC_BIT]); // R4
  AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (rst)
    rx_dma_req |-> raw_stat[RX_SVC_BIT]); // R4
  AST_TX_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (raw_stat[TX_ERR_BIT] && !tx_err_clr) |=> raw_stat[TX_ERR_BIT]); // R5
  AST_RX_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    rx_err_evt |=> raw_stat[RX_ERR_BIT]); // R5
  AST_TX_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (tx_err_clr && !tx_err_evt) |=> !raw_stat[TX_ERR_BIT]); // R6
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
    raw_stat[3:2] == 2'b00 && masked_stat[3:2] == 2'b00); // R7
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (masked_stat & ~raw_stat) == '0); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == ($past(masked_stat) != '0)); // R8
endmodule

bind fifo_svc_req_ctrl fsr_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst),
  .tx_level(tx_level), .tx_limit(tx_limit),
  .tx_err_evt(tx_err_evt), .tx_err_clr(tx_err_clr),
  .rx_level(rx_level), .rx_limit(rx_limit),
  .rx_err_evt(rx_err_evt), .rx_err_clr(rx_err_clr),
  .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
);

// File: tb/sim_fifo_svc_req_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_svc_req_ctrl;
  localparam int unsigned LW = 6;

  typedef struct packed {
    logic [LW-1:0] txl;
    logic [LW-1:0] txlim;
    logic [LW-1:0] rxl;
    logic [LW-1:0] rxlim;
    logic          txen;
    logic          rxen;
    logic [5:0]    mask;
    logic          e_tx;
    logic          e_rx;
    logic          e_irq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{6'd7,  6'd8,  6'd9,  6'd8,  1'b1, 1'b1, 6'h33, 1'b1, 1'b1, 1'b1},
    '{6'd8,  6'd8,  6'd8,  6'd8,  1'b1, 1'b1, 6'h33, 1'b0, 1'b0, 1'b0},
    '{6'd0,  6'd0,  6'd0,  6'd0,  1'b1, 1'b1, 6'h33, 1'b0, 1'b0, 1'b0},
    '{6'd3,  6'd8,  6'd2,  6'd8,  1'b0, 1'b1, 6'h33, 1'b1, 1'b0, 1'b0},
    '{6'd3,  6'd8,  6'd20, 6'd8,  1'b1, 1'b1, 6'h0C, 1'b1, 1'b1, 1'b0},
    '{6'd10, 6'd4,  6'd32, 6'd31, 1'b1, 1'b1, 6'h10, 1'b0, 1'b1, 1'b1},
    '{6'd31, 6'd32, 6'd0,  6'd5,  1'b1, 1'b0, 6'h01, 1'b1, 1'b0, 1'b1},
    '{6'd5,  6'd8,  6'd12, 6'd8,  1'b1, 1'b1, 6'h00, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] tx_level = '0, tx_limit = '0, rx_level = '0, rx_limit = '0;
  logic tx_svc_en = 1'b0, rx_svc_en = 1'b0;
  logic tx_err_evt = 1'b0, tx_err_clr = 1'b0, rx_err_evt = 1'b0, rx_err_clr = 1'b0;
  logic [5:0] irq_mask = '0;
  logic [5:0] raw_stat, masked_stat;
  logic irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_svc_req_ctrl #(.FIFO_DEPTH(32)) u0 (
    .clk(clk), .rst(rst),
    .tx_level(tx_level), .tx_limit(tx_limit), .tx_svc_en(tx_svc_en),
    .tx_err_evt(tx_err_evt), .tx_err_clr(tx_err_clr),
    .rx_level(rx_level), .rx_limit(rx_limit), .rx_svc_en(rx_svc_en),
    .rx_err_evt(rx_err_evt), .rx_err_clr(rx_err_clr),
    .irq_mask(irq_mask), .raw_stat(raw_stat), .masked_stat(masked_stat),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [5:0] em;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 raw in reset", raw_stat, 0);
    chk("R1 irq/dma in reset", {irq, tx_dma_req, rx_dma_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 raw after reset", raw_stat, 0);
    chk("R1 masked after reset", masked_stat, 0);

    // Table walk: R2 R3 R4 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      tx_level = VEC[i].txl;  tx_limit = VEC[i].txlim;
      rx_level = VEC[i].rxl;  rx_limit = VEC[i].rxlim;
      tx_svc_en = VEC[i].txen; rx_svc_en = VEC[i].rxen;
      irq_mask = VEC[i].mask;
      repeat (2) @(negedge clk);
      em = '0;
      em[0] = VEC[i].e_tx & VEC[i].txen & VEC[i].mask[0];
      em[4] = VEC[i].e_rx & VEC[i].rxen & VEC[i].mask[4];
      chk($sformatf("R2 tx service v%0d", i), raw_stat[0], VEC[i].e_tx);
      chk($sformatf("R3 rx service v%0d", i), raw_stat[4], VEC[i].e_rx);
      chk($sformatf("R4 tx dma v%0d", i), tx_dma_req, VEC[i].e_tx & VEC[i].txen);
      chk($sformatf("R4 rx dma v%0d", i), rx_dma_req, VEC[i].e_rx & VEC[i].rxen);
      chk($sformatf("R7 masked v%0d", i), masked_stat, em);
      chk($sformatf("R8 irq v%0d", i), irq, VEC[i].e_irq);
      if (i == 1) chk("R9 equal level no request", {raw_stat[4], raw_stat[0]}, 0);
    end

    // Quiet levels for error tests
    tx_level = 6'd10; tx_limit = 6'd2; rx_level = 6'd0; rx_limit = 6'd4;
    irq_mask = 6'h00;
    repeat (2) @(negedge clk);
    chk("R2 R3 quiet levels", {raw_stat[4], raw_stat[0]}, 0);

    // R5: tx error sets one edge later and sticks
    tx_err_evt = 1'b1;
    @(negedge clk);
    tx_err_evt = 1'b0;
    chk("R5 tx err set", raw_stat[1], 1);
    repeat (4) @(negedge clk);
    chk("R5 tx err sticky", raw_stat[1], 1);
    chk("R8 irq off while masked", irq, 0);

    // R7/R8: enable mask1, masked at once, irq one edge later
    irq_mask = 6'h02;
    #1;
    chk("R7 masked err bit", masked_stat, 6'h02);
    chk("R8 irq not yet", irq, 0);
    @(negedge clk);
    chk("R8 irq one edge after mask", irq, 1);

    // R6: clear
    tx_err_clr = 1'b1;
    @(negedge clk);
    tx_err_clr = 1'b0;
    chk("R6 tx err cleared", raw_stat[1], 0);
    chk("R8 irq still high one cycle", irq, 1);
    @(negedge clk);
    chk("R8 irq falls after clear", irq, 0);

    // R6: simultaneous event and clear on rx -> set wins
    rx_err_evt = 1'b1; rx_err_clr = 1'b1;
    @(negedge clk);
    rx_err_evt = 1'b0; rx_err_clr = 1'b0;
    chk("R6 rx set wins over clear", raw_stat[5], 1);
    chk("R7 reserved bits zero", raw_stat[3:2], 0);

    // R7: reserved mask bits do nothing
    irq_mask = 6'h0C;
    @(negedge clk);
    chk("R7 reserved mask no effect", {masked_stat, irq}, 0);

    // R1: reset clears sticky error
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears sticky", raw_stat, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule